// File: doc/BRIEF.md
# Cascaded Level-Interrupt Aggregator

This block gathers a set of level-sensitive interrupt sources into a single interrupt line for a host. Each source has an enable bit and a delivery mask bit. An enabled source that is high latches a pending bit. The output line is high while any pending bit has its mask bit set. The host reaches the block over a small memory-mapped bus of 16-bit registers placed on 4-byte boundaries.

The enable bits and the mask bits are never written directly. Each has a write-one-to-set register and a write-one-to-clear register, so software never needs a read-modify-write. Pending bits are read from the status register and are cleared by writing ones back to it. A source that is still high while its pending bit is being cleared sets that bit again at once, so a level source keeps its request alive until it is served.

Register offsets (byte addresses) are: status 0x00, enable-set 0x04, enable-clear 0x08, mask-set 0x0C, mask-clear 0x10. Reads return their data on `bus_rdata_o` in the cycle after the request. The read data holds its value until the next read.

Top module: `aggr_irq_top`

## Requirements
- R1: While reset is applied, and after it is released, all enable, mask and pending bits are 0, `irq_o` is 0 and `bus_rdata_o` is 0.
- R2: A write to 0x04 sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged. A read of 0x04 returns the enable bits.
- R3: A write to 0x08 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R4: A write to 0x0C sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged. A read of 0x0C returns the mask bits.
- R5: A write to 0x10 clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R6: A pending bit is set at every clock edge where its source input is high and its enable bit is 1. A source whose enable bit is 0 never sets its pending bit. A set pending bit stays set after the source goes low.
- R7: A write to 0x00 clears each pending bit whose data bit is 1. Zero data bits have no effect. If the source of a bit is enabled and high at the same edge, that bit stays set.
- R8: `irq_o` is a register. After every clock edge it equals the OR of (pending AND mask), taken over the state that edge produced.
- R9: After a mask-clear write followed by a status write of the same one-hot value, `irq_o` stays low for that source, even while the source is still high. It rises again once the mask bit is set.
- R10: Writing 0xFFFF to mask-clear, then to enable-set, then to status, with all sources low, leaves every source enabled, every mask bit clear and nothing pending.
- R11: Reads of 0x08, 0x10, unmapped offsets and misaligned addresses (address bits [1:0] not 00) return 0 and change no state. Writes to these addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid_i | input | 1 | Bus access request for this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (5) | Byte address |
| bus_wdata_i | input | DATA_W (16) | Write data |
| bus_rdata_o | output | DATA_W (16) | Read data, valid the cycle after a read |
| src_i | input | NUM_SRC (16) | Level-sensitive interrupt sources, synchronous to clk_i |
| irq_o | output | 1 | Cascaded level interrupt to the host |

## Verification
The hardest case to reach is an acknowledge write that lands in the same cycle as a source that is enabled and still high, with a mask bit that was just cleared. The set-wins rule and the masked-output rule then have to hold together. Directed sequences hold a source high across a mask-clear write and a status write of the same one-hot value, then set the mask again. Seeded random traffic with sparse source patterns causes many further collisions between acknowledges and live sources. Every cycle is checked against a bench model of the register state.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
  localparam int REG_STRIDE = 4;

  localparam int IDX_STATUS   = 0;
  localparam int IDX_EN_SET   = 1;
  localparam int IDX_EN_CLR   = 2;
  localparam int IDX_MASK_SET = 3;
  localparam int IDX_MASK_CLR = 4;

  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_ENABLE = 2'd2,
    RSEL_MASK   = 2'd3
  } rsel_e;

  typedef struct packed {
    logic status;
    logic en_set;
    logic en_clr;
    logic mask_set;
    logic mask_clr;
  } wstrb_t;
endpackage

// File: rtl/aggr_rst_sync.sv
module aggr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/aggr_decode.sv
module aggr_decode
  import aggr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wstrb_t            wstrb_o,
  output logic              rd_o,
  output rsel_e             rsel_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    wstrb_o = '0;
    rsel_o  = RSEL_NONE;
    rd_o    = valid_i && !write_i;
    if (valid_i && aligned) begin
      case (idx)
        IDX_W'(IDX_STATUS):   begin wstrb_o.status   = write_i; rsel_o = RSEL_STATUS; end
        IDX_W'(IDX_EN_SET):   begin wstrb_o.en_set   = write_i; rsel_o = RSEL_ENABLE; end
        IDX_W'(IDX_EN_CLR):   wstrb_o.en_clr   = write_i;
        IDX_W'(IDX_MASK_SET): begin wstrb_o.mask_set = write_i; rsel_o = RSEL_MASK; end
        IDX_W'(IDX_MASK_CLR): wstrb_o.mask_clr = write_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/aggr_setclr_reg.sv
module aggr_setclr_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] state_o,
  output logic [W-1:0] state_next_o
);
  logic [W-1:0] state_q, state_d;
  logic         state_ce;

  always_comb begin
    state_d = state_q;
    if (set_i) state_d = state_d | bits_i;
    if (clr_i) state_d = state_d & ~bits_i;
  end

  assign state_ce = set_i || clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= '0;
    else if (state_ce) state_q <= state_d;
  end

  assign state_o      = state_q;
  assign state_next_o = state_d;
endmodule

// File: rtl/aggr_pending.sv
module aggr_pending #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] enable_i,
  input  logic         ack_i,
  input  logic [W-1:0] ack_bits_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] pend_next_o
);
  logic [W-1:0] pend_q, pend_d, ack_vec;
  logic         pend_ce;

  always_comb begin
    ack_vec = ack_i ? ack_bits_i : '0;
    // a live enabled source overrides its own acknowledge
    pend_d  = (pend_q & ~ack_vec) | (src_i & enable_i);
  end

  assign pend_ce = (pend_d != pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (pend_ce) pend_q <= pend_d;
  end

  assign pend_o      = pend_q;
  assign pend_next_o = pend_d;
endmodule

// File: rtl/aggr_irq_top.sv
module aggr_irq_top
  import aggr_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic              irq_o
);
  logic               rst_n;
  wstrb_t             wstrb;
  logic               rd;
  rsel_e              rsel;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] en_q, en_d, mask_q, mask_d, pend_q, pend_d;
  logic [NUM_SRC-1:0] rd_src;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               irq_q, irq_d;

  assign wbits = bus_wdata_i[NUM_SRC-1:0];

  aggr_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n)
  );

  aggr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i(bus_valid_i),
    .write_i(bus_write_i),
    .addr_i (bus_addr_i),
    .wstrb_o(wstrb),
    .rd_o   (rd),
    .rsel_o (rsel)
  );

  aggr_setclr_reg #(.W(NUM_SRC)) u_enable (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .set_i       (wstrb.en_set),
    .clr_i       (wstrb.en_clr),
    .bits_i      (wbits),
    .state_o     (en_q),
    .state_next_o(en_d)
  );

  aggr_setclr_reg #(.W(NUM_SRC)) u_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .set_i       (wstrb.mask_set),
    .clr_i       (wstrb.mask_clr),
    .bits_i      (wbits),
    .state_o     (mask_q),
    .state_next_o(mask_d)
  );

  aggr_pending #(.W(NUM_SRC)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .src_i      (src_i),
    .enable_i   (en_q),
    .ack_i      (wstrb.status),
    .ack_bits_i (wbits),
    .pend_o     (pend_q),
    .pend_next_o(pend_d)
  );

  // read path
  always_comb begin
    case (rsel)
      RSEL_STATUS: rd_src = pend_q;
      RSEL_ENABLE: rd_src = en_q;
      RSEL_MASK:   rd_src = mask_q;
      default:     rd_src = '0;
    endcase
    rdata_d = '0;
    rdata_d[NUM_SRC-1:0] = rd_src;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  // output line from the state the edge produces
  assign irq_d = |(pend_d & mask_d);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/aggr_irq_chk.sv
module aggr_irq_chk #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic               bus_valid_i,
  input logic               bus_write_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [DATA_W-1:0]  bus_rdata_o,
  input logic               irq_o
);
  logic               wr;
  logic               w_stat, w_ens, w_enc, w_mks, w_mkc;
  logic [NUM_SRC-1:0] wb;

  assign wr     = bus_valid_i && bus_write_i;
  assign wb     = bus_wdata_i[NUM_SRC-1:0];
  assign w_stat = wr && (bus_addr_i == ADDR_W'(5'h00));
  assign w_ens  = wr && (bus_addr_i == ADDR_W'(5'h04));
  assign w_enc  = wr && (bus_addr_i == ADDR_W'(5'h08));
  assign w_mks  = wr && (bus_addr_i == ADDR_W'(5'h0C));
  assign w_mkc  = wr && (bus_addr_i == ADDR_W'(5'h10));

  always @(posedge clk_i) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!irq_o && bus_rdata_o == '0);
    end
  end

  assert_enable_set_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    w_ens |=> ((en_q & $past(wb)) == $past(wb)));

  assert_enable_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    w_enc |=> ((en_q & $past(wb)) == '0));

  assert_mask_set_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    w_mks |=> ((mask_q & $past(wb)) == $past(wb)));

  assert_mask_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    w_mkc |=> ((mask_q & $past(wb)) == '0));

  assert_pend_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|(src_i & en_q)) |=> ((pend_q & $past(src_i & en_q)) == $past(src_i & en_q)));

  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    w_stat |=> ((pend_q & $past(wb & ~(src_i & en_q))) == '0));

  assert_irq_level_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o == (|(pend_q & mask_q)));

  assert_masked_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
endmodule

bind aggr_irq_top aggr_irq_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .bus_valid_i(bus_valid_i),
  .bus_write_i(bus_write_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .src_i      (src_i),
  .en_q       (en_q),
  .mask_q     (mask_q),
  .pend_q     (pend_q),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o)
);

// File: tb/test_aggr_irq_top.sv
module test_aggr_irq_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid_i = 1'b0;
  logic        bus_write_i = 1'b0;
  logic [4:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [15:0] src_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_en = '0, m_mk = '0, m_pd = '0;
  logic        m_irq = 1'b0;

  always #5 clk = ~clk;

  aggr_irq_top i_aggr_irq_top (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .src_i(src_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [4:0] a);
    case (a)
      5'h00:   return m_pd;
      5'h04:   return m_en;
      5'h0C:   return m_mk;
      default: return 16'h0000;
    endcase
  endfunction

  // one bus cycle; model follows the requirements
  task automatic step(input logic v, input logic w, input logic [4:0] a,
                      input logic [15:0] d, input logic [15:0] s, input string tag);
    logic [15:0] ack, pd_n, en_n, mk_n, rd_exp;
    @(negedge clk);
    bus_valid_i = v; bus_write_i = w; bus_addr_i = a; bus_wdata_i = d; src_i = s;
    rd_exp = model_read(a);
    ack  = (v && w && a == 5'h00) ? d : 16'h0;
    pd_n = (m_pd & ~ack) | (s & m_en);
    en_n = m_en; mk_n = m_mk;
    if (v && w && a == 5'h04) en_n = en_n | d;
    if (v && w && a == 5'h08) en_n = en_n & ~d;
    if (v && w && a == 5'h0C) mk_n = mk_n | d;
    if (v && w && a == 5'h10) mk_n = mk_n & ~d;
    @(posedge clk); #1;
    m_pd = pd_n; m_en = en_n; m_mk = mk_n; m_irq = |(pd_n & mk_n);
    chk("R8 irq level", {15'h0, irq_o}, {15'h0, m_irq});
    if (v && !w) chk(tag, bus_rdata_o, rd_exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [15:0] s);
    step(1'b1, 1'b1, a, d, s, "write");
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [15:0] s,
                        input logic [15:0] exp, input string tag);
    step(1'b1, 1'b0, a, 16'h0, s, tag);
    chk(tag, bus_rdata_o, exp);
  endtask

  task automatic idle(input logic [15:0] s);
    step(1'b0, 1'b0, 5'h00, 16'h0, s, "idle");
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] seed;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq in reset", {15'h0, irq_o}, 16'h0);
    chk("R1 rdata in reset", bus_rdata_o, 16'h0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 irq after reset", {15'h0, irq_o}, 16'h0);
    rd_exp(5'h00, 16'h0, 16'h0000, "R1 status zero");
    rd_exp(5'h04, 16'h0, 16'h0000, "R1 enable zero");
    rd_exp(5'h0C, 16'h0, 16'h0000, "R1 mask zero");

    // R2 / R3
    wr(5'h04, 16'h00A5, 16'h0);
    rd_exp(5'h04, 16'h0, 16'h00A5, "R2 enable set");
    wr(5'h04, 16'h0100, 16'h0);
    rd_exp(5'h04, 16'h0, 16'h01A5, "R2 zeros keep");
    wr(5'h08, 16'h0005, 16'h0);
    rd_exp(5'h04, 16'h0, 16'h01A0, "R3 enable clear");

    // R4 / R5
    wr(5'h0C, 16'h8001, 16'h0);
    rd_exp(5'h0C, 16'h0, 16'h8001, "R4 mask set");
    wr(5'h10, 16'h0001, 16'h0);
    rd_exp(5'h0C, 16'h0, 16'h8000, "R5 mask clear");

    // R6
    idle(16'h0002);
    rd_exp(5'h00, 16'h0, 16'h0000, "R6 disabled source ignored");
    idle(16'h0020);
    rd_exp(5'h00, 16'h0, 16'h0020, "R6 latched after source low");

    // R7
    wr(5'h00, 16'h0000, 16'h0);
    rd_exp(5'h00, 16'h0, 16'h0020, "R7 zero ack no effect");
    wr(5'h00, 16'h0020, 16'h0);
    rd_exp(5'h00, 16'h0, 16'h0000, "R7 ack clears");
    wr(5'h00, 16'h0080, 16'h0080);
    rd_exp(5'h00, 16'h0, 16'h0080, "R7 live source wins");
    wr(5'h00, 16'h0080, 16'h0);
    rd_exp(5'h00, 16'h0, 16'h0000, "R7 ack after release");

    // R8 / R9
    wr(5'h0C, 16'h0080, 16'h0);
    idle(16'h0080);
    chk("R8 irq rises", {15'h0, irq_o}, 16'h0001);
    wr(5'h10, 16'h0080, 16'h0080);
    chk("R9 masked low", {15'h0, irq_o}, 16'h0000);
    wr(5'h00, 16'h0080, 16'h0080);
    chk("R9 after ack low", {15'h0, irq_o}, 16'h0000);
    repeat (3) idle(16'h0080);
    chk("R9 stays low", {15'h0, irq_o}, 16'h0000);
    wr(5'h0C, 16'h0080, 16'h0080);
    chk("R9 unmask raises", {15'h0, irq_o}, 16'h0001);

    // R10
    wr(5'h10, 16'hFFFF, 16'h0);
    wr(5'h04, 16'hFFFF, 16'h0);
    wr(5'h00, 16'hFFFF, 16'h0);
    rd_exp(5'h04, 16'h0, 16'hFFFF, "R10 all enabled");
    rd_exp(5'h0C, 16'h0, 16'h0000, "R10 all masked");
    rd_exp(5'h00, 16'h0, 16'h0000, "R10 none pending");
    chk("R10 irq low", {15'h0, irq_o}, 16'h0000);

    // R11
    wr(5'h0C, 16'h00F0, 16'h0030);
    rd_exp(5'h08, 16'h0, 16'h0000, "R11 read enable-clear");
    rd_exp(5'h10, 16'h0, 16'h0000, "R11 read mask-clear");
    rd_exp(5'h14, 16'h0, 16'h0000, "R11 read unmapped");
    rd_exp(5'h05, 16'h0, 16'h0000, "R11 read misaligned");
    wr(5'h14, 16'hFFFF, 16'h0);
    wr(5'h06, 16'hFFFF, 16'h0);
    wr(5'h1C, 16'hFFFF, 16'h0);
    rd_exp(5'h00, 16'h0, 16'h0030, "R11 status untouched");
    rd_exp(5'h04, 16'h0, 16'hFFFF, "R11 enable untouched");
    rd_exp(5'h0C, 16'h0, 16'h00F0, "R11 mask untouched");

    // seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [4:0]  a;
      logic [15:0] d, s;
      logic        v, w;
      a = 5'((($urandom % 8)) * 4);
      if ($urandom % 16 == 0) a = a | 5'($urandom % 4);
      d = 16'($urandom) & 16'($urandom);
      s = 16'($urandom) & 16'($urandom) & 16'($urandom);
      v = ($urandom % 4) != 0;
      w = $urandom % 2;
      step(v, w, a, d, s, "R7 random read");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule